// File: doc/BRIEF.md
# Line Padding Ratio Calculator

This block serves a display path in which a panel's physical line count is larger than the logical image height, for example when an external splitter needs extra blank lines between image lines. Given the two heights, it finds the shortest repeating run of real ("active") lines and filler ("dummy") lines that stretches the logical height to the physical one. It then reports that pattern together with the padded height that a line-insertion stage downstream will use.

A request is a one-cycle `start_i` pulse with both heights present. Trivial cases finish in one cycle: padding switched off, an invalid request, no padding needed, or a physical height equal to the cached result. Otherwise an iterative Euclid engine finds the greatest common divisor, one remainder step per cycle. Two shift-subtract dividers then reduce both heights by it. The reduced pattern is checked against fixed limits before it is accepted. Results stay on the outputs until the next completed request. A rejected request leaves the previous pattern in place and raises the error flag.

Top module: `lpad_ratio_calc`

## Requirements
- R1: After reset, `done_o`, `err_o`, `act_o`, `dum_o` and `pad_h_o` are all zero.
- R2: A request with physical height 0 completes one cycle after the start edge with `pad_h_o`, `act_o`, `dum_o` and `err_o` all zero.
- R3: A request whose physical height is below the logical height completes one cycle after the start edge with `err_o` = 1. `act_o`, `dum_o` and `pad_h_o` keep their previous values.
- R4: A request whose physical height equals the nonzero logical height completes one cycle after the start edge with `pad_h_o`, `act_o`, `dum_o` and `err_o` all zero.
- R5: A request whose physical height equals the current nonzero `pad_h_o` completes one cycle after the start edge with `err_o` = 0. The other outputs are unchanged and nothing is recomputed.
- R6: In all other cases, with g = gcd(physical, logical), the result is `act_o` = logical/g, `dum_o` = physical/g − logical/g, `pad_h_o` = physical and `err_o` = 0. If k remainder steps take (physical, logical) to a zero divisor, `done_o` comes k + HW + 2 cycles after the start edge.
- R7: When the computed pattern has more than 93 active lines or more than 45 dummy lines, the request completes with `err_o` = 1 and the previous `act_o`, `dum_o` and `pad_h_o` are kept. Exactly 93 active lines or exactly 45 dummy lines is accepted.
- R8: A `start_i` pulse that arrives while a request is being computed is ignored: it neither changes the result nor produces a second `done_o`.
- R9: `done_o` is high for one cycle per accepted request, and `act_o`, `dum_o` and `pad_h_o` change only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse; heights sampled with it |
| phys_h_i | input | 16 | Physical (padded) panel height in lines |
| logi_h_i | input | 16 | Logical display height in lines |
| act_o | output | 7 | Active lines per pattern period |
| dum_o | output | 6 | Dummy lines per pattern period |
| pad_h_o | output | 16 | Padded height, 0 when padding is off |
| err_o | output | 1 | Last completed request was rejected |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
Shortcut requests (zero, invalid, equal or cached height) are due one cycle after the start edge. A computed pattern is due k + 18 cycles after it at the default width, where k is the number of Euclid remainder steps for that height pair. The bench's reference model counts k on its own for each accepted request and arms a countdown to that exact cycle. On every clock, half a period after the edge, it compares the strobe, the error flag and all three result outputs against the model. A strobe that comes early or late, or a result that changes outside the strobe, is therefore caught in the cycle where it happens.

// File: rtl/lpad_pkg.sv
package lpad_pkg;
   typedef enum logic [1:0] {
      LP_IDLE = 2'd0,
      LP_GCD  = 2'd1,
      LP_DIV  = 2'd2
   } lpad_state_e;

   localparam int LP_DEF_HW      = 16;
   localparam int LP_DEF_MAX_ACT = 93;
   localparam int LP_DEF_MAX_DUM = 45;
endpackage

// File: rtl/lpad_gcd.sv
module lpad_gcd #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] g_o,
   output logic         fin_o
);
   logic [W-1:0] a_q, b_q;
   logic         run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q   <= '0;
         b_q   <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         a_q   <= a_i;
         b_q   <= b_i;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (b_q != '0) begin
            a_q <= b_q;
            b_q <= a_q % b_q;
         end else begin
            run_q <= 1'b0;
         end
      end
   end

   assign g_o   = a_q;
   assign fin_o = run_q && (b_q == '0);
endmodule

// File: rtl/lpad_div.sv
module lpad_div #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   output logic [W-1:0] quo_o,
   output logic         fin_o
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  rem_q, quo_q;
   logic [CW-1:0] cnt_q;
   logic          run_q, fin_q;
   logic [W:0]    trial;
   logic [W:0]    diff;

   assign trial = {rem_q, quo_q[W-1]};
   assign diff  = trial - {1'b0, den_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (go) begin
            rem_q <= '0;
            quo_q <= num_i;
            cnt_q <= CW'(W);
            run_q <= 1'b1;
         end else if (run_q) begin
            if (trial >= {1'b0, den_i}) begin
               rem_q <= diff[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
               rem_q <= trial[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end
         end
      end
   end

   assign quo_o = quo_q;
   assign fin_o = fin_q;
endmodule

// File: rtl/lpad_ratio_calc.sv
module lpad_ratio_calc
   import lpad_pkg::*;
#(
   parameter int HW      = LP_DEF_HW,
   parameter int MAX_ACT = LP_DEF_MAX_ACT,
   parameter int MAX_DUM = LP_DEF_MAX_DUM,
   localparam int ACT_W  = $clog2(MAX_ACT + 1),
   localparam int DUM_W  = $clog2(MAX_DUM + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [HW-1:0]    phys_h_i,
   input  logic [HW-1:0]    logi_h_i,
   output logic [ACT_W-1:0] act_o,
   output logic [DUM_W-1:0] dum_o,
   output logic [HW-1:0]    pad_h_o,
   output logic             err_o,
   output logic             done_o
);
   localparam int NDIV = 2;

   generate
      if (HW < 2) begin : g_bad_hw
         $error("HW must be at least 2");
      end
      if (MAX_ACT < 1 || MAX_DUM < 1) begin : g_bad_lim
         $error("pattern limits must be positive");
      end
      if (ACT_W > HW || DUM_W > HW) begin : g_bad_width
         $error("pattern limits exceed the height width");
      end
   endgenerate

   lpad_state_e      state_q;
   logic [HW-1:0]    phys_q, logi_q;
   logic [ACT_W-1:0] act_q;
   logic [DUM_W-1:0] dum_q;
   logic [HW-1:0]    pad_q;
   logic             err_q, done_q;

   logic             accept, quick;
   logic             gcd_load, gcd_fin;
   logic [HW-1:0]    gcd_val;
   logic             div_go;
   logic [HW-1:0]    div_num [NDIV];
   logic [HW-1:0]    div_quo [NDIV];
   logic [NDIV-1:0]  div_fin;
   logic [HW-1:0]    dum_full;

   assign accept = (state_q == LP_IDLE) && start_i;
   assign quick  = (phys_h_i == '0) || (phys_h_i <= logi_h_i) ||
                   ((pad_q != '0) && (phys_h_i == pad_q));
   assign gcd_load = accept && !quick;

   lpad_gcd #(.W(HW)) u_gcd (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (gcd_load),
      .a_i   (phys_h_i),
      .b_i   (logi_h_i),
      .g_o   (gcd_val),
      .fin_o (gcd_fin)
   );

   assign div_go     = (state_q == LP_GCD) && gcd_fin && (gcd_val != '0);
   assign div_num[0] = logi_q;
   assign div_num[1] = phys_q;

   generate
      for (genvar i = 0; i < NDIV; i++) begin : g_div
         lpad_div #(.W(HW)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .go    (div_go),
            .num_i (div_num[i]),
            .den_i (gcd_val),
            .quo_o (div_quo[i]),
            .fin_o (div_fin[i])
         );
      end
   endgenerate

   assign dum_full = div_quo[1] - div_quo[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LP_IDLE;
         phys_q  <= '0;
         logi_q  <= '0;
         act_q   <= '0;
         dum_q   <= '0;
         pad_q   <= '0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            LP_IDLE: begin
               if (accept) begin
                  phys_q <= phys_h_i;
                  logi_q <= logi_h_i;
                  if (phys_h_i == '0 || phys_h_i == logi_h_i) begin
                     act_q  <= '0;
                     dum_q  <= '0;
                     pad_q  <= '0;
                     err_q  <= 1'b0;
                     done_q <= 1'b1;
                  end else if (phys_h_i < logi_h_i) begin
                     err_q  <= 1'b1;
                     done_q <= 1'b1;
                  end else if (phys_h_i == pad_q) begin
                     err_q  <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     state_q <= LP_GCD;
                  end
               end
            end
            LP_GCD: begin
               if (gcd_fin) begin
                  if (gcd_val == '0) begin
                     err_q   <= 1'b1;
                     done_q  <= 1'b1;
                     state_q <= LP_IDLE;
                  end else begin
                     state_q <= LP_DIV;
                  end
               end
            end
            LP_DIV: begin
               if (div_fin[0]) begin
                  if (div_quo[0] > HW'(MAX_ACT) || dum_full > HW'(MAX_DUM)) begin
                     err_q <= 1'b1;
                  end else begin
                     act_q <= div_quo[0][ACT_W-1:0];
                     dum_q <= dum_full[DUM_W-1:0];
                     pad_q <= phys_q;
                     err_q <= 1'b0;
                  end
                  done_q  <= 1'b1;
                  state_q <= LP_IDLE;
               end
            end
            default: state_q <= LP_IDLE;
         endcase
      end
   end

   assign act_o   = act_q;
   assign dum_o   = dum_q;
   assign pad_h_o = pad_q;
   assign err_o   = err_q;
   assign done_o  = done_q;
endmodule

// File: rtl/lpad_ratio_chk.sv
module lpad_ratio_chk #(
   parameter int HW      = 16,
   parameter int MAX_ACT = 93,
   parameter int MAX_DUM = 45,
   parameter int ACT_W   = 7,
   parameter int DUM_W   = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [ACT_W-1:0] act_o,
   input logic [DUM_W-1:0] dum_o,
   input logic [HW-1:0]    pad_h_o,
   input logic             err_o,
   input logic             done_o
);
   // R3
   err_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> ($stable(act_o) && $stable(dum_o) && $stable(pad_h_o)));

   // R7
   pattern_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (act_o <= ACT_W'(MAX_ACT) && dum_o <= DUM_W'(MAX_DUM)));

   // R9
   result_only_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !($stable(act_o) && $stable(dum_o) && $stable(pad_h_o)) |-> done_o);

   // R2
   zero_pad_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o && pad_h_o == '0) |-> (act_o == '0 && dum_o == '0));

   // R6
   padded_has_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o && pad_h_o != '0) |-> (dum_o != '0));
endmodule

bind lpad_ratio_calc lpad_ratio_chk #(
   .HW      (HW),
   .MAX_ACT (MAX_ACT),
   .MAX_DUM (MAX_DUM),
   .ACT_W   (ACT_W),
   .DUM_W   (DUM_W)
) u_lpad_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .act_o   (act_o),
   .dum_o   (dum_o),
   .pad_h_o (pad_h_o),
   .err_o   (err_o),
   .done_o  (done_o)
);

// File: tb/lpad_ratio_calc_test.sv
`timescale 1ns/1ps
module lpad_ratio_calc_test;
   localparam int HW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [HW-1:0] phys_h_i = '0;
   logic [HW-1:0] logi_h_i = '0;
   logic [6:0]    act_o;
   logic [5:0]    dum_o;
   logic [HW-1:0] pad_h_o;
   logic          err_o, done_o;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit finished = 0;

   int m_act = 0, m_dum = 0, m_pad = 0, m_err = 0, m_done = 0, m_cd = 0;
   int p_act = 0, p_dum = 0, p_pad = 0, p_err = 0, p_keep = 0;
   string cur_tag = "R1";

   always #2.5 clk = ~clk;

   lpad_ratio_calc uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .phys_h_i (phys_h_i),
      .logi_h_i (logi_h_i),
      .act_o    (act_o),
      .dum_o    (dum_o),
      .pad_h_o  (pad_h_o),
      .err_o    (err_o),
      .done_o   (done_o)
   );

   // reference model, updated at each rising edge
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_act = 0; m_dum = 0; m_pad = 0; m_err = 0; m_done = 0; m_cd = 0;
      end else begin
         m_done = 0;
         if (m_cd > 0) begin
            m_cd--;
            if (m_cd == 0) begin
               m_done = 1;
               m_err  = p_err;
               if (!p_keep) begin
                  m_act = p_act; m_dum = p_dum; m_pad = p_pad;
               end
            end
         end else if (start_i) begin
            int ph, lg;
            ph = phys_h_i;
            lg = logi_h_i;
            if (ph == 0 || ph == lg) begin
               m_act = 0; m_dum = 0; m_pad = 0; m_err = 0; m_done = 1;
            end else if (ph < lg) begin
               m_err = 1; m_done = 1;
            end else if (ph == m_pad) begin
               m_err = 0; m_done = 1;
            end else begin
               int a, b, t, k;
               a = ph; b = lg; k = 0;
               while (b != 0) begin
                  t = a % b; a = b; b = t; k++;
               end
               p_act = lg / a;
               p_dum = ph / a - p_act;
               p_pad = ph;
               if (p_act > 93 || p_dum > 45) begin
                  p_err = 1; p_keep = 1;
               end else begin
                  p_err = 0; p_keep = 0;
               end
               m_cd = k + HW + 2;
            end
         end
      end
   end

   // compare half a period after each rising edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         total++;
         if (done_o !== m_done[0] || err_o !== m_err[0] || act_o !== m_act[6:0] ||
             dum_o !== m_dum[5:0] || pad_h_o !== m_pad[HW-1:0]) begin
            bad++;
            $display("FAIL %s: got done=%0d err=%0d act=%0d dum=%0d pad=%0d exp done=%0d err=%0d act=%0d dum=%0d pad=%0d",
                     cur_tag, done_o, err_o, act_o, dum_o, pad_h_o,
                     m_done, m_err, m_act, m_dum, m_pad);
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      if (cycles > 150000 && !finished) begin
         finished = 1;
         bad++;
         total++;
         $display("FAIL watchdog: got running exp finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic pulse(input int ph, input int lg);
      @(negedge clk);
      start_i  = 1'b1;
      phys_h_i = HW'(ph);
      logi_h_i = HW'(lg);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic req(input int ph, input int lg, input string tag);
      cur_tag = tag;
      pulse(ph, lg);
      while (m_cd != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      total++;
      if (done_o !== 1'b0 || err_o !== 1'b0 || act_o !== '0 || dum_o !== '0 || pad_h_o !== '0) begin
         bad++;
         $display("FAIL R1: got done=%0d err=%0d act=%0d dum=%0d pad=%0d exp all 0",
                  done_o, err_o, act_o, dum_o, pad_h_o);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      req(2400, 2340, "R6");   // g=60 -> 39 active, 1 dummy
      req(2400, 2340, "R5");   // cached height
      req(0, 100, "R2");       // feature off
      req(500, 800, "R3");     // invalid request keeps previous values
      req(3000, 1000, "R6");   // 1 active, 2 dummy
      req(1080, 1080, "R4");   // no padding
      req(1000, 999, "R7");    // 999 active lines: rejected
      req(94, 93, "R7");       // exactly 93 active accepted
      req(95, 94, "R7");       // 94 active rejected
      req(46, 1, "R7");        // exactly 45 dummy accepted
      req(47, 1, "R7");        // 46 dummy rejected
      req(5, 0, "R6");         // zero logical height
      req(1920, 1200, "R6");   // g=240 -> 5 active, 3 dummy
      // R8: second start while busy is ignored
      cur_tag = "R8";
      pulse(2560, 1600);
      repeat (3) @(negedge clk);
      pulse(0, 0);
      while (m_cd != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      req(2560, 1600, "R5");   // cache hit proves the ignored start left no trace
      // R9: back-to-back shortcut requests each give their own strobe
      cur_tag = "R9";
      pulse(0, 7);
      pulse(9, 9);
      repeat (3) @(negedge clk);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule